// File: doc/BRIEF.md
# Edge-Triggered Interrupt Source Controller

This block gathers interrupt requests for a digital I/O port group and presents them as one level-sensitive interrupt line. Four external channels each watch two input lines of their port (line 0 and line 4). The lines are asynchronous, so each one is synchronized and its transitions are detected on the block clock. Each channel is enabled or disabled by a two-bit source-mode field, and an edge-select bit picks a rising or a falling trigger. A qualifying edge sets the channel's sticky pending flag. A separate 8-bit monitor supplies two one-cycle event pulses, pattern match and change of state. These set their own flags in channel 0's control byte when they are enabled. A software trigger register adds a further request.

The host reads and writes one byte register bus. Pending flags are cleared by writing 1 to them. A global clear register drops every flag and the software request together. While a flag is set, further edges on its source are dropped and not queued. The interrupt output is high while any enabled flag or the software request is pending. A second output carries an identical copy of it for triggering outside equipment.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00, all flags and the software request are clear, and irq and irq_ext are low.
- R2: Channel n's control byte sits at address 0x10+n. Bit 6 is the edge select (1 rising, 0 falling), bits 5:4 are the source mode and bit 7 is the pending flag, all readable. For channels 1 to 3, bits 3:0 always read 0.
- R3: Mode 2'b10 makes line 0 the only source. Mode 2'b01 makes line 0 or line 4 a source. Modes 2'b00 and 2'b11 set no flag.
- R4: Only the transition chosen by the edge select sets the flag. Changing an input line between clock edges shows the flag after the third following rising clock edge.
- R5: A flag stays set until cleared. Writing its control byte with bit 7 = 1 clears it. Writing with bit 7 = 0 leaves it set while the edge and mode bits take the written values.
- R6: An edge that arrives while the flag is set is dropped, so the flag stays clear after it is cleared.
- R7: In channel 0's byte, bit 0 enables pattern match and bit 2 enables change of state. An enabled pm_evt pulse sets bit 1 and an enabled cos_evt pulse sets bit 3, one cycle later. Writing 1 to bit 1 or bit 3 clears that flag. Pulses that arrive while disabled set nothing.
- R8: A write of any value to address 0x18 raises irq in the next cycle.
- R9: A write of any value to address 0x1A clears every flag and the software request, and irq is low in the next cycle.
- R10: irq is the OR of the software request, each channel flag whose mode is 2'b10 or 2'b01, and each monitor flag whose enable is set. irq_ext always equals irq. A flag masked by its mode stays readable.
- R11: Several sources can be pending at once. Clearing one of them leaves irq high while another is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pc_line0 | input | NUM_CH | Line 0 of each channel's port, asynchronous |
| pc_line4 | input | NUM_CH | Line 4 of each channel's port, asynchronous |
| pm_evt | input | 1 | Pattern-match event pulse from the monitor |
| cos_evt | input | 1 | Change-of-state event pulse from the monitor |
| irq | output | 1 | Level interrupt request, active high |
| irq_ext | output | 1 | External copy of irq |

## Verification
A sweep runs over every channel, all four mode codes, both edge selects, both lines and both transition directions. Each vector checks the flag and irq against a selection computed in the bench, which separates the disabled codes from the single-line and dual-line codes and the matching transition from the opposite one. Directed patterns then set flags and apply further edges or pulses while they are set. These show that a cleared flag does not reappear, and they separate write-one clearing from write-zero retention. Mixed pending sets of a channel flag, a monitor flag and the software request are cleared one by one and all at once, to separate the per-flag clear path from the global clear path and from masking by mode.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    localparam int          BUS_AW    = 5;
    localparam logic [4:0]  CTRL_BASE = 5'h10;
    localparam logic [4:0]  SWI_ADDR  = 5'h18;
    localparam logic [4:0]  CLR_ADDR  = 5'h1A;

    // source-mode field codes
    localparam logic [1:0]  MODE_L0   = 2'b10;
    localparam logic [1:0]  MODE_L04  = 2'b01;

    typedef struct packed {
        logic       flag;
        logic       rising;
        logic [1:0] mode;
    } chan_cfg_t;

    typedef struct packed {
        logic cos_flag;
        logic cos_en;
        logic pm_flag;
        logic pm_en;
    } mon_cfg_t;

endpackage

// File: rtl/irq_line_edge.sv
module irq_line_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[W-2] & ~sh_q[W-1];
    assign fall_o = ~sh_q[W-2] &  sh_q[W-1];

endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_src_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BUS_AW-1:0]       addr,
    input  logic [7:0]              wdata,
    input  logic [NUM_CH-1:0]       l0_rise,
    input  logic [NUM_CH-1:0]       l0_fall,
    input  logic [NUM_CH-1:0]       l4_rise,
    input  logic [NUM_CH-1:0]       l4_fall,
    input  logic                    pm_evt,
    input  logic                    cos_evt,
    output chan_cfg_t [NUM_CH-1:0]  ch_q,
    output mon_cfg_t                mon_q,
    output logic                    swi_q
);
    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] ch;
        mon_cfg_t               mon;
        logic                   swi;
    } state_t;

    state_t st_d, st_q;

    logic glob_clr, sel, hit0, hit4, trig, clr, sel0;

    always_comb begin
        st_d     = st_q;
        glob_clr = wr_en && (addr == CLR_ADDR);
        sel = 1'b0; hit0 = 1'b0; hit4 = 1'b0; trig = 1'b0; clr = 1'b0;

        for (int i = 0; i < NUM_CH; i++) begin
            sel  = wr_en && (addr == CTRL_BASE + 5'(i));
            hit0 = st_q.ch[i].rising ? l0_rise[i] : l0_fall[i];
            hit4 = st_q.ch[i].rising ? l4_rise[i] : l4_fall[i];
            trig = ((st_q.ch[i].mode == MODE_L0)  && hit0) ||
                   ((st_q.ch[i].mode == MODE_L04) && (hit0 || hit4));
            if (sel) begin
                st_d.ch[i].rising = wdata[6];
                st_d.ch[i].mode   = wdata[5:4];
            end
            // clearing dominates; edges on a set flag are dropped
            clr = glob_clr || (sel && wdata[7]);
            st_d.ch[i].flag = clr ? 1'b0 : (st_q.ch[i].flag || trig);
        end

        sel0 = wr_en && (addr == CTRL_BASE);
        if (sel0) begin
            st_d.mon.pm_en  = wdata[0];
            st_d.mon.cos_en = wdata[2];
        end
        st_d.mon.pm_flag  = (glob_clr || (sel0 && wdata[1])) ? 1'b0 :
                            (st_q.mon.pm_flag || (pm_evt && st_q.mon.pm_en));
        st_d.mon.cos_flag = (glob_clr || (sel0 && wdata[3])) ? 1'b0 :
                            (st_q.mon.cos_flag || (cos_evt && st_q.mon.cos_en));

        st_d.swi = glob_clr ? 1'b0 : (st_q.swi || (wr_en && (addr == SWI_ADDR)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_q  = st_q.ch;
    assign mon_q = st_q.mon;
    assign swi_q = st_q.swi;

endmodule

// File: rtl/irq_src_out.sv
module irq_src_out
    import irq_src_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  chan_cfg_t [NUM_CH-1:0] ch_q,
    input  mon_cfg_t               mon_q,
    input  logic                   swi_q,
    input  logic [BUS_AW-1:0]      addr,
    output logic [7:0]             rdata,
    output logic                   irq
);
    logic any_d;

    always_comb begin
        any_d = swi_q
              | (mon_q.pm_flag  & mon_q.pm_en)
              | (mon_q.cos_flag & mon_q.cos_en);
        rdata = 8'h00;
        for (int i = 0; i < NUM_CH; i++) begin
            any_d = any_d | (ch_q[i].flag &
                    ((ch_q[i].mode == MODE_L0) || (ch_q[i].mode == MODE_L04)));
            if (addr == CTRL_BASE + 5'(i)) begin
                rdata[7:4] = {ch_q[i].flag, ch_q[i].rising, ch_q[i].mode};
                if (i == 0) begin
                    rdata[3:0] = {mon_q.cos_flag, mon_q.cos_en,
                                  mon_q.pm_flag,  mon_q.pm_en};
                end
            end
        end
    end

    assign irq = any_d;

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NUM_CH-1:0] pc_line0,
    input  logic [NUM_CH-1:0] pc_line4,
    input  logic              pm_evt,
    input  logic              cos_evt,
    output logic              irq,
    output logic              irq_ext
);
    logic [NUM_CH-1:0] l0_rise, l0_fall, l4_rise, l4_fall;
    chan_cfg_t [NUM_CH-1:0] ch_q;
    mon_cfg_t               mon_q;
    logic                   swi_q;
    logic                   irq_w;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_line
        irq_line_edge #(.STAGES(SYNC_STAGES)) u_l0 (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (pc_line0[i]),
            .rise_o (l0_rise[i]),
            .fall_o (l0_fall[i])
        );
        irq_line_edge #(.STAGES(SYNC_STAGES)) u_l4 (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (pc_line4[i]),
            .rise_o (l4_rise[i]),
            .fall_o (l4_fall[i])
        );
    end

    irq_src_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .l0_rise (l0_rise),
        .l0_fall (l0_fall),
        .l4_rise (l4_rise),
        .l4_fall (l4_fall),
        .pm_evt  (pm_evt),
        .cos_evt (cos_evt),
        .ch_q    (ch_q),
        .mon_q   (mon_q),
        .swi_q   (swi_q)
    );

    irq_src_out #(.NUM_CH(NUM_CH)) u_out (
        .ch_q  (ch_q),
        .mon_q (mon_q),
        .swi_q (swi_q),
        .addr  (addr),
        .rdata (rdata),
        .irq   (irq_w)
    );

    assign irq     = irq_w;
    assign irq_ext = irq_w;

endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk
    import irq_src_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [4:0]             addr,
    input logic                   wd_flag,
    input logic                   wd_pm,
    input logic                   pm_evt,
    input logic                   irq,
    input chan_cfg_t [NUM_CH-1:0] ch_q,
    input mon_cfg_t               mon_q
);
    // R8
    swi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SWI_ADDR) |=> irq);

    // R9
    glob_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CLR_ADDR) |=> !irq);

    // R7
    pm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_evt && mon_q.pm_en &&
         !(wr_en && (addr == CLR_ADDR || (addr == CTRL_BASE && wd_pm))))
        |=> mon_q.pm_flag);

    // R10
    pending_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q.pm_flag && mon_q.pm_en) |-> irq);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R5
        sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_q[i].flag &&
             !(wr_en && (addr == CLR_ADDR || (addr == CTRL_BASE + 5'(i) && wd_flag))))
            |=> ch_q[i].flag);

        // R3
        flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_q[i].flag) |->
            ($past(ch_q[i].mode) == MODE_L0 || $past(ch_q[i].mode) == MODE_L04));
    end

endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wd_flag (wdata[7]),
    .wd_pm   (wdata[1]),
    .pm_evt  (pm_evt),
    .irq     (irq),
    .ch_q    (ch_q),
    .mon_q   (mon_q)
);

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;
    import irq_src_pkg::*;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [4:0]     addr = '0;
    logic [7:0]     wdata = '0;
    logic [NCH-1:0] l0 = '0;
    logic [NCH-1:0] l4 = '0;
    logic           pm_evt = 1'b0;
    logic           cos_evt = 1'b0;
    logic [7:0]     rdata;
    logic           irq, irq_ext;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_src_ctrl #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pc_line0(l0), .pc_line4(l4), .pm_evt(pm_evt),
        .cos_evt(cos_evt), .irq(irq), .irq_ext(irq_ext)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, {7'b0, irq}, {7'b0, exp});
        chk({req, " irq_ext copy R10"}, {7'b0, irq_ext}, {7'b0, irq});
    endtask

    task automatic pulse_pm();
        @(negedge clk); pm_evt = 1'b1;
        @(negedge clk); pm_evt = 1'b0;
    endtask

    task automatic pulse_cos();
        @(negedge clk); cos_evt = 1'b1;
        @(negedge clk); cos_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            rd(CTRL_BASE + 5'(c), v);
            chk("R1 reset ctrl byte", v, 8'h00);
        end
        chk_irq("R1 reset irq", 1'b0);

        // R2: layout and readback
        wr(5'h11, 8'h6F);
        rd(5'h11, v); chk("R2 ch1 readback, low nibble zero", v, 8'h60);
        wr(5'h10, 8'h05);
        rd(5'h10, v); chk("R2 ch0 enables readback", v, 8'h05);

        // R3 / R4: sweep over channel, mode, edge, line, direction
        for (int c = 0; c < NCH; c++)
        for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
        for (int ln = 0; ln < 2; ln++)
        for (int dir = 0; dir < 2; dir++) begin
            logic [1:0] mv;
            logic s0, s4, fire;
            mv   = 2'(m);
            s0   = (mv == 2'b10) || (mv == 2'b01);
            s4   = (mv == 2'b01);
            fire = ((ln == 0) ? s0 : s4) && (dir == e);
            wr(CTRL_BASE + 5'(c), 8'h80);
            if (ln == 0) l0[c] = (dir == 0); else l4[c] = (dir == 0);
            idle(5);
            wr(CTRL_BASE + 5'(c), {1'b1, e[0], mv, 4'b0});
            wr(CLR_ADDR, 8'h00);
            if (ln == 0) l0[c] = (dir == 1); else l4[c] = (dir == 1);
            idle(2);
            rd(CTRL_BASE + 5'(c), v);
            chk("R4 flag not before third clock edge", v[7], 1'b0);
            idle(2);
            rd(CTRL_BASE + 5'(c), v);
            chk("R3 R4 flag by mode, edge, line", v, {fire, e[0], mv, 4'b0});
            chk_irq("R3 irq follows flag", fire);
        end

        // R5 / R6 on channel 1
        wr(5'h11, 8'h80);
        l0[1] = 1'b0; l4[1] = 1'b0;
        idle(5);
        wr(5'h11, 8'hE0);
        l0[1] = 1'b1; idle(5);
        rd(5'h11, v); chk("R5 flag set", v, 8'hE0);
        wr(5'h11, 8'h60);
        rd(5'h11, v); chk("R5 write 0 keeps flag", v, 8'hE0);
        l0[1] = 1'b0; idle(3); l0[1] = 1'b1; idle(5);
        wr(5'h11, 8'hE0);
        rd(5'h11, v); chk("R5 write 1 clears flag", v, 8'h60);
        idle(4);
        rd(5'h11, v); chk("R6 dropped edge not queued", v, 8'h60);
        chk_irq("R6 irq low after clear", 1'b0);

        // R7 monitor events
        wr(5'h10, 8'h05);
        pulse_pm();
        rd(5'h10, v); chk("R7 pm flag set", v, 8'h07);
        chk_irq("R7 pm raises irq", 1'b1);
        pulse_cos();
        rd(5'h10, v); chk("R7 cos flag set", v, 8'h0F);
        wr(5'h10, 8'h07);
        rd(5'h10, v); chk("R7 pm flag cleared only", v, 8'h0D);
        wr(5'h10, 8'h0D);
        rd(5'h10, v); chk("R7 cos flag cleared", v, 8'h05);
        chk_irq("R7 irq low", 1'b0);
        wr(5'h10, 8'h00);
        pulse_pm(); pulse_cos();
        rd(5'h10, v); chk("R7 disabled events ignored", v, 8'h00);
        chk_irq("R7 disabled irq low", 1'b0);

        // R8 / R9 software trigger and global clear
        wr(SWI_ADDR, 8'h5A);
        chk_irq("R8 software trigger", 1'b1);
        wr(CLR_ADDR, 8'h00);
        chk_irq("R9 clear drops software", 1'b0);
        l0[1] = 1'b0; idle(5); l0[1] = 1'b1; idle(5);
        wr(5'h10, 8'h05);
        pulse_pm();
        wr(SWI_ADDR, 8'h01);
        chk_irq("R11 several pending", 1'b1);
        wr(CLR_ADDR, 8'hFF);
        rd(5'h11, v); chk("R9 clear ch1 flag", v, 8'h60);
        rd(5'h10, v); chk("R9 clear pm flag", v, 8'h05);
        chk_irq("R9 irq low after global clear", 1'b0);

        // R11 partial clearing
        l0[1] = 1'b0; idle(5); l0[1] = 1'b1; idle(5);
        pulse_pm();
        chk_irq("R11 two pending", 1'b1);
        wr(5'h11, 8'hE0);
        chk_irq("R11 pm still pending", 1'b1);
        wr(5'h10, 8'h07);
        chk_irq("R11 all cleared", 1'b0);

        // R10 mode masks a pending flag
        l0[1] = 1'b0; idle(5); l0[1] = 1'b1; idle(5);
        wr(5'h11, 8'h40);
        rd(5'h11, v); chk("R10 masked flag readable", v, 8'hC0);
        chk_irq("R10 masked irq low", 1'b0);
        wr(5'h11, 8'h60);
        rd(5'h11, v); chk("R10 unmasked readback", v, 8'hE0);
        chk_irq("R10 unmasked irq high", 1'b1);

        finish_run();
    end

endmodule